// File: doc/BRIEF.md
# Fractional PLL Rate Calculator

This block is a sequential arithmetic unit for the rate arithmetic of a fractional-N synthesiser. In the forward direction it computes the output rate from a parent rate, an integer multiplier, a pre-divider and an optional fraction. The fraction is a numerator over a programmable denominator. In the reverse direction it takes a target rate, a multiplier and a pre-divider, and it derives the fraction numerator that brings the output closest to the target.

A job starts with a one-cycle `start` pulse while the block is idle. All operands are captured on that edge. `busy` then stays high until the job ends. The job ends with a one-cycle `done` pulse, and `result` holds the answer from that cycle until the next job completes. Every division runs on a single restoring divider that produces one quotient bit per cycle over a 64-bit datapath. A forward job with a fraction uses the divider twice. Any other job uses it once or not at all.

Top module: `frac_pll_calc`

## Requirements
- R1: With `dir_rev`=0 and `frac_on`=0, `result` = ceil(`parent_rate` × `mult` / `prediv`).
- R2: With `dir_rev`=0 and `frac_on`=1, the fraction term ceil(`parent_rate` × `frac_val` / D) is added to `parent_rate` × `mult`. The sum is then divided by `prediv` with rounding up. D is the fraction denominator.
- R3: D equals `frac_lim` when `frac_lim` is non-zero. D equals 2^17 (2 to the power of the fraction field width) when `frac_lim` is zero. This holds in both directions.
- R4: A forward job with `prediv`=0 returns 0.
- R5: A reverse job (`dir_rev`=1) returns 0 in three cases: `target_rate` < floor(`parent_rate` × `mult` / `prediv`), `prediv`=0, or `parent_rate`=0.
- R6: When `frac_on`=0, `frac_val` has no effect on a forward result.
- R7: With `round_near`=0, the reverse result is floor(`target_rate` × `prediv` × D / `parent_rate`) − `mult` × D.
- R8: With `round_near`=1, the quotient in R7 is rounded to the nearest integer, with halves rounding up.
- R9: The reverse result never exceeds D − 1. Larger values are clamped to D − 1.
- R10: If the reverse quotient is below `mult` × D, the reverse result is 0.
- R11: `busy` rises in the cycle after an accepted `start`. `done` is high for exactly one cycle, and `busy` falls after that cycle.
- R12: A `start` while `busy` is high is ignored. This includes the cycle in which `done` is high. No extra `done` follows, and `result` keeps the earlier job's answer.
- R13: After reset, `busy`, `done` and `result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse; accepted only when idle |
| dir_rev | input | 1 | 0 computes a rate, 1 computes a fraction |
| parent_rate | input | 32 | Input reference rate |
| mult | input | 9 | Integer feedback multiplier |
| prediv | input | 5 | Input pre-divider |
| frac_val | input | 17 | Fraction numerator (forward only) |
| frac_on | input | 1 | Fraction field present (forward only) |
| frac_lim | input | 18 | Fraction denominator; 0 selects 2^17 |
| target_rate | input | 32 | Requested rate (reverse only) |
| round_near | input | 1 | Reverse division rounds to nearest |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Rate or fraction of the last job |

## Verification
A new launch request can arrive in the same cycle that the running job completes. This coincidence matters most. The bench provokes it by watching for `done` and driving `start` with different operands in that same cycle. It judges the outcome by checking that no further `done` appears over a long window and that `result` still carries the first job's value. A launch in the middle of a divide is provoked the same way and judged the same way. The table walk covers the remaining arithmetic corners: rounding direction, the bail comparison, clamping and quotient underflow.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;

  localparam int ACC_W = 64;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_FDIV,
    ST_NDIV,
    ST_RDIV,
    ST_FIN
  } calc_st_t;

  // numerator adjusted so a floor divide yields the ceiling
  function automatic logic [ACC_W-1:0] up_num(input logic [ACC_W-1:0] x,
                                               input logic [ACC_W-1:0] d);
    return x + d - ACC_W'(1);
  endfunction

  // numerator adjusted so a floor divide yields round-to-nearest
  function automatic logic [ACC_W-1:0] near_num(input logic [ACC_W-1:0] x,
                                                 input logic [ACC_W-1:0] d);
    return x + (d >> 1);
  endfunction

  // subtract the integer part, floor at zero, cap at denominator minus one
  function automatic logic [ACC_W-1:0] fit_frac(input logic [ACC_W-1:0] q,
                                                input logic [ACC_W-1:0] base,
                                                input logic [ACC_W-1:0] dmax);
    logic [ACC_W-1:0] r;
    if (q < base) return '0;
    r = q - base;
    if (r > dmax - ACC_W'(1)) return dmax - ACC_W'(1);
    return r;
  endfunction

endpackage

// File: rtl/pll_calc_prep.sv
module pll_calc_prep
  import pll_calc_pkg::*;
#(
  parameter int RATE_W = 32,
  parameter int M_W    = 9,
  parameter int N_W    = 5,
  parameter int F_W    = 17
) (
  input  logic [RATE_W-1:0] p_rate,
  input  logic [M_W-1:0]    p_mult,
  input  logic [N_W-1:0]    p_div,
  input  logic [F_W-1:0]    p_frac,
  input  logic [F_W:0]      p_lim,
  input  logic [RATE_W-1:0] p_target,
  output logic [ACC_W-1:0]  denom,
  output logic [ACC_W-1:0]  prod_pm,
  output logic [ACC_W-1:0]  prod_pf,
  output logic [ACC_W-1:0]  prod_tnd,
  output logic [ACC_W-1:0]  int_base,
  output logic              below_int
);

  localparam logic [ACC_W-1:0] DEF_DEN = ACC_W'(1) << F_W;

  logic [ACC_W-1:0] rate_x, mult_x, div_x, frac_x, tgt_x;

  always_comb begin
    rate_x   = ACC_W'(p_rate);
    mult_x   = ACC_W'(p_mult);
    div_x    = ACC_W'(p_div);
    frac_x   = ACC_W'(p_frac);
    tgt_x    = ACC_W'(p_target);
    denom    = (p_lim == '0) ? DEF_DEN : ACC_W'(p_lim);
    prod_pm  = rate_x * mult_x;
    prod_pf  = rate_x * frac_x;
    prod_tnd = tgt_x * div_x * denom;
    int_base = mult_x * denom;
    // target < floor(pm/n)  <=>  (target+1)*n <= pm ; no divide needed
    below_int = ((tgt_x + ACC_W'(1)) * div_x) <= prod_pm;
  end

endmodule

// File: rtl/pll_calc_div.sv
module pll_calc_div #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic [W-1:0] quo,
  output logic         fin
);

  localparam int CW = $clog2(W);

  logic [CW-1:0] cnt;
  logic          run;
  logic [W:0]    rem;
  logic [W-1:0]  den_q, num_q;
  logic [W:0]    shifted;
  logic          fits;
  logic          last_step;

  assign shifted   = {rem[W-1:0], quo[W-1]};
  assign fits      = shifted >= {1'b0, den_q};
  assign last_step = run && (cnt == CW'(W-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      run   <= 1'b0;
      rem   <= '0;
      quo   <= '0;
      den_q <= '0;
      num_q <= '0;
      fin   <= 1'b0;
    end else if (go) begin
      cnt   <= '0;
      run   <= 1'b1;
      rem   <= '0;
      quo   <= num;
      den_q <= den;
      num_q <= num;
      fin   <= 1'b0;
    end else if (run) begin
      rem <= fits ? (shifted - {1'b0, den_q}) : shifted;
      quo <= {quo[W-2:0], fits};
      cnt <= cnt + CW'(1);
      if (last_step) run <= 1'b0;
      fin <= last_step;
    end else begin
      fin <= 1'b0;
    end
  end

  // R1 quotient and remainder reconstruct the dividend
  div_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && den_q != '0) |->
      ((2*W)'(quo) * (2*W)'(den_q) + (2*W)'(rem) == (2*W)'(num_q)))
    else $error("divider identity broken");

  // R1 remainder below divisor
  div_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && den_q != '0) |-> (rem < {1'b0, den_q}))
    else $error("divider remainder too large");

endmodule

// File: rtl/frac_pll_calc.sv
module frac_pll_calc
  import pll_calc_pkg::*;
#(
  parameter int RATE_W = 32,
  parameter int M_W    = 9,
  parameter int N_W    = 5,
  parameter int F_W    = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_rev,
  input  logic [RATE_W-1:0] parent_rate,
  input  logic [M_W-1:0]    mult,
  input  logic [N_W-1:0]    prediv,
  input  logic [F_W-1:0]    frac_val,
  input  logic              frac_on,
  input  logic [F_W:0]      frac_lim,
  input  logic [RATE_W-1:0] target_rate,
  input  logic              round_near,
  output logic              busy,
  output logic              done,
  output logic [ACC_W-1:0]  result
);

  calc_st_t st;

  logic              o_rev, o_fen, o_rc;
  logic [RATE_W-1:0] o_p, o_t;
  logic [M_W-1:0]    o_m;
  logic [N_W-1:0]    o_n;
  logic [F_W-1:0]    o_f;
  logic [F_W:0]      o_lim;

  logic [ACC_W-1:0] denom, prod_pm, prod_pf, prod_tnd, int_base;
  logic             below_int;
  logic [ACC_W-1:0] div_x;

  logic             div_go, div_fin;
  logic [ACC_W-1:0] div_num, div_den, div_quo;
  logic [ACC_W-1:0] res_q;

  // named internal events
  logic accept, n_zero, rev_bail;
  assign accept   = start && (st == ST_IDLE);
  assign n_zero   = (o_n == '0);
  assign rev_bail = n_zero || (o_p == '0) || below_int;
  assign div_x    = ACC_W'(o_n);

  pll_calc_prep #(
    .RATE_W(RATE_W), .M_W(M_W), .N_W(N_W), .F_W(F_W)
  ) u_prep (
    .p_rate   (o_p),
    .p_mult   (o_m),
    .p_div    (o_n),
    .p_frac   (o_f),
    .p_lim    (o_lim),
    .p_target (o_t),
    .denom    (denom),
    .prod_pm  (prod_pm),
    .prod_pf  (prod_pf),
    .prod_tnd (prod_tnd),
    .int_base (int_base),
    .below_int(below_int)
  );

  pll_calc_div #(.W(ACC_W)) u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (div_go),
    .num  (div_num),
    .den  (div_den),
    .quo  (div_quo),
    .fin  (div_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      o_rev   <= 1'b0;
      o_fen   <= 1'b0;
      o_rc    <= 1'b0;
      o_p     <= '0;
      o_t     <= '0;
      o_m     <= '0;
      o_n     <= '0;
      o_f     <= '0;
      o_lim   <= '0;
      div_go  <= 1'b0;
      div_num <= '0;
      div_den <= '0;
      res_q   <= '0;
    end else begin
      div_go <= 1'b0;
      case (st)
        ST_IDLE: if (accept) begin
          o_rev <= dir_rev;
          o_fen <= frac_on;
          o_rc  <= round_near;
          o_p   <= parent_rate;
          o_t   <= target_rate;
          o_m   <= mult;
          o_n   <= prediv;
          o_f   <= frac_val;
          o_lim <= frac_lim;
          st    <= ST_SETUP;
        end
        ST_SETUP: begin
          if (!o_rev) begin
            if (n_zero) begin
              res_q <= '0;
              st    <= ST_FIN;
            end else if (o_fen) begin
              div_go  <= 1'b1;
              div_num <= up_num(prod_pf, denom);
              div_den <= denom;
              st      <= ST_FDIV;
            end else begin
              div_go  <= 1'b1;
              div_num <= up_num(prod_pm, div_x);
              div_den <= div_x;
              st      <= ST_NDIV;
            end
          end else if (rev_bail) begin
            res_q <= '0;
            st    <= ST_FIN;
          end else begin
            div_go  <= 1'b1;
            div_num <= o_rc ? near_num(prod_tnd, ACC_W'(o_p)) : prod_tnd;
            div_den <= ACC_W'(o_p);
            st      <= ST_RDIV;
          end
        end
        ST_FDIV: if (div_fin) begin
          div_go  <= 1'b1;
          div_num <= up_num(prod_pm + div_quo, div_x);
          div_den <= div_x;
          st      <= ST_NDIV;
        end
        ST_NDIV: if (div_fin) begin
          res_q <= div_quo;
          st    <= ST_FIN;
        end
        ST_RDIV: if (div_fin) begin
          res_q <= fit_frac(div_quo, int_base, denom);
          st    <= ST_FIN;
        end
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (st != ST_IDLE);
  assign done   = (st == ST_FIN);
  assign result = res_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle");

  // R11
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy) else $error("busy did not rise");

  // R12
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> ($stable(o_p) && $stable(o_t) && $stable(o_n) && $stable(o_m)))
    else $error("operands changed while busy");

  // R4
  nzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !o_rev && n_zero) |-> (result == '0))
    else $error("zero pre-divider gave non-zero rate");

  // R9
  frac_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && o_rev) |-> (result < denom))
    else $error("fraction not below denominator");

  // R12
  div_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_go |-> (st == ST_FDIV || st == ST_NDIV || st == ST_RDIV))
    else $error("divider launched outside a divide state");

endmodule

// File: tb/test_frac_pll_calc.sv
module test_frac_pll_calc;

  typedef struct packed {
    logic        rev;
    logic [31:0] p;
    logic [8:0]  m;
    logic [4:0]  n;
    logic [16:0] f;
    logic        fen;
    logic [17:0] lim;
    logic [31:0] t;
    logic        rc;
    logic [63:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'd24,   9'd100, 5'd1, 17'd0,     1'b0, 18'd0,    32'd0,    1'b0, 64'd2400,  8'd1},  // R1
    '{1'b0, 32'd24,   9'd100, 5'd3, 17'd0,     1'b0, 18'd0,    32'd0,    1'b0, 64'd800,   8'd1},  // R1
    '{1'b0, 32'd25,   9'd10,  5'd3, 17'd0,     1'b0, 18'd0,    32'd0,    1'b0, 64'd84,    8'd1},  // R1 ceil
    '{1'b0, 32'd24,   9'd100, 5'd1, 17'd1,     1'b1, 18'd0,    32'd0,    1'b0, 64'd2401,  8'd2},  // R2
    '{1'b0, 32'd1000, 9'd10,  5'd1, 17'd65536, 1'b1, 18'd0,    32'd0,    1'b0, 64'd10500, 8'd3},  // R3
    '{1'b0, 32'd3,    9'd2,   5'd2, 17'd333,   1'b1, 18'd1000, 32'd0,    1'b0, 64'd4,     8'd2},  // R2
    '{1'b0, 32'd24,   9'd100, 5'd1, 17'd99999, 1'b0, 18'd1000, 32'd0,    1'b0, 64'd2400,  8'd6},  // R6
    '{1'b0, 32'd24,   9'd100, 5'd0, 17'd5,     1'b1, 18'd0,    32'd0,    1'b0, 64'd0,     8'd4},  // R4
    '{1'b1, 32'd24,   9'd100, 5'd1, 17'd0,     1'b0, 18'd1000, 32'd2412, 1'b0, 64'd500,   8'd7},  // R7
    '{1'b1, 32'd24,   9'd100, 5'd1, 17'd0,     1'b0, 18'd1000, 32'd2413, 1'b1, 64'd542,   8'd8},  // R8
    '{1'b1, 32'd24,   9'd100, 5'd1, 17'd0,     1'b0, 18'd1000, 32'd2413, 1'b0, 64'd541,   8'd7},  // R7
    '{1'b1, 32'd24,   9'd100, 5'd1, 17'd0,     1'b0, 18'd1000, 32'd2399, 1'b0, 64'd0,     8'd5},  // R5
    '{1'b1, 32'd24,   9'd100, 5'd1, 17'd0,     1'b0, 18'd1000, 32'd2400, 1'b0, 64'd0,     8'd5},  // R5
    '{1'b1, 32'd24,   9'd100, 5'd1, 17'd0,     1'b0, 18'd1000, 32'd2500, 1'b0, 64'd999,   8'd9},  // R9
    '{1'b1, 32'd24,   9'd100, 5'd1, 17'd0,     1'b0, 18'd0,    32'd2406, 1'b0, 64'd32768, 8'd3},  // R3
    '{1'b1, 32'd3,    9'd1,   5'd2, 17'd0,     1'b0, 18'd1000, 32'd1,    1'b0, 64'd0,     8'd10}  // R10
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dir_rev = 1'b0;
  logic [31:0] parent_rate = '0;
  logic [8:0]  mult = '0;
  logic [4:0]  prediv = '0;
  logic [16:0] frac_val = '0;
  logic        frac_on = 1'b0;
  logic [17:0] frac_lim = '0;
  logic [31:0] target_rate = '0;
  logic        round_near = 1'b0;
  logic        busy, done;
  logic [63:0] result;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  frac_pll_calc i_frac_pll_calc (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_rev(dir_rev),
    .parent_rate(parent_rate), .mult(mult), .prediv(prediv),
    .frac_val(frac_val), .frac_on(frac_on), .frac_lim(frac_lim),
    .target_rate(target_rate), .round_near(round_near),
    .busy(busy), .done(done), .result(result)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    dir_rev     = v.rev;
    parent_rate = v.p;
    mult        = v.m;
    prediv      = v.n;
    frac_val    = v.f;
    frac_on     = v.fen;
    frac_lim    = v.lim;
    target_rate = v.t;
    round_near  = v.rc;
  endtask

  task automatic launch(input vec_t v);
    apply(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 1000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    int cyc;
    int dones;
    logic [63:0] keep;
    vec_t alt;
    repeat (3) @(negedge clk);
    // R13 reset state
    check(busy == 1'b0 && done == 1'b0, "R13 busy/done after reset",
          {62'd0, busy, done}, 64'd0);
    check(result == 64'd0, "R13 result after reset", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      launch(VECS[i]);
      wait_done(cyc);
      check(done == 1'b1, $sformatf("R11 done seen row %0d", i), {63'd0, done}, 64'd1);
      check(result == VECS[i].exp, $sformatf("R%0d row %0d", VECS[i].req, i),
            result, VECS[i].exp);
      @(negedge clk);
      repeat (2) @(negedge clk);
    end

    // R11 busy rises after start, done lasts one cycle, busy falls after
    launch(VECS[3]);
    check(busy == 1'b1, "R11 busy after start", {63'd0, busy}, 64'd1);
    wait_done(cyc);
    check(busy == 1'b1 && done == 1'b1, "R11 busy during done",
          {62'd0, busy, done}, 64'd3);
    @(negedge clk);
    check(done == 1'b0, "R11 done single cycle", {63'd0, done}, 64'd0);
    check(busy == 1'b0, "R11 busy drops", {63'd0, busy}, 64'd0);

    // R12 start in the middle of a divide is ignored
    launch(VECS[0]);
    repeat (20) @(negedge clk);
    alt = VECS[7];
    launch(alt);
    dones = 0;
    for (int k = 0; k < 400; k++) begin
      if (done) dones++;
      @(negedge clk);
    end
    check(dones == 1, "R12 one done for mid-run start", 64'(dones), 64'd1);
    check(result == 64'd2400, "R12 result kept after mid-run start", result, 64'd2400);

    // R12 start in the same cycle as done is ignored
    launch(VECS[8]);
    wait_done(cyc);
    keep = result;
    check(keep == 64'd500, "R7 result before coincident start", keep, 64'd500);
    apply(VECS[1]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dones = 0;
    for (int k = 0; k < 400; k++) begin
      if (done) dones++;
      @(negedge clk);
    end
    check(dones == 0, "R12 no done after coincident start", 64'(dones), 64'd0);
    check(result == keep, "R12 result held after coincident start", result, keep);
    check(busy == 1'b0, "R12 stays idle", {63'd0, busy}, 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule